// File: doc/BRIEF.md
# Sixteen-bit two-operand ALU with decimal add

This block is the combinational execute stage of a small 16-bit controller datapath. Each evaluation takes a destination operand, a source operand, the current status byte and a 4-bit operation code, and returns a result, a write-back enable and an updated status byte. One more input picks word or byte operation. It has no clock and no storage.

The operation set covers plain and carry-chained addition and subtraction, a packed-decimal add and four bitwise operations. Two of the operations only look at the operands: compare and bit test update the flags and never request a write-back. The carry-in comes from the carry bit of the incoming status byte. Carry, zero, negative and overflow are rewritten in place. All other status bits pass through untouched.

Operand fetch, addressing, the register file and instruction decode sit outside this block.

Top module: `alu16_core`

## Requirements
- R1: Operation codes are 0 move, 1 add, 2 add-with-carry, 3 subtract-with-carry, 4 subtract, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 exclusive-or, 11 and. `wr_o` is 1 for every code from 0 to 11 except 5 and 7. Codes 12 to 15 drive `res_o` to 0, clear `wr_o` and leave the status byte unchanged.
- R2: Add returns dst+src and add-with-carry returns dst+src+C, where C is `stat_i[0]`. The new carry is the carry out of the top bit of the active size.
- R3: Subtract and compare form dst+~src+1. Subtract-with-carry forms dst+~src+C. The new carry is the carry out of that sum, so 1 means no borrow.
- R4: Overflow is set on the add forms when both operands have the same sign and the result sign differs from it. On the subtract forms it is set when the operand signs differ and the result sign differs from dst.
- R5: Decimal add treats each nibble as one digit, starting from the lowest. A digit sum above 9 has 6 added, keeps its low 4 bits and passes a carry of 1 to the next digit. The carry out of the top digit becomes C. Z and N are set from the result and V is unchanged.
- R6: Bit clear returns dst AND NOT src, bit set returns dst OR src, and and returns dst AND src.
- R7: The flag positions are C at bit 0, Z at bit 1, N at bit 2 and V at bit 7. Status bits 3 to 6 always pass from `stat_i` to `stat_o` unchanged.
- R8: Z is set when the result of the active size is zero. N copies bit 7 of the result in byte mode and bit 15 in word mode.
- R9: In byte mode (`byte_i`=1) only operand bits 7:0 take part in the operation, and `res_o[15:8]` is 0.
- R10: Move returns src and leaves the status byte unchanged. Bit clear and bit set also leave the status byte unchanged.
- R11: And and bit test set C to the inverse of Z and clear V. Exclusive-or also sets C to the inverse of Z, and sets V only when both operands are negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| op_i | input | 4 | Operation code (see R1) |
| byte_i | input | 1 | 1 selects byte size, 0 selects word size |
| stat_i | input | 8 | Current status byte; bit 0 supplies the carry-in |
| res_o | output | 16 | Operation result |
| wr_o | output | 1 | Result should be written back to the destination |
| stat_o | output | 8 | Updated status byte |

## Verification
The hardest cases to reach are the decimal carry ripples across every digit and the byte-mode carry taken out of digit 1. With random operands these almost never occur, because random nibbles are seldom valid digits that sum to exactly 9 along the chain. Directed vectors therefore cover them: 0x0999+1, 0x9999+1, and a byte add of 0x99+1 with unrelated upper bits in dst. Signed overflow at both sizes and the no-borrow carry are also forced with directed boundary operands. A long pseudo-random sweep then runs over all sixteen codes, both sizes and random status bytes.

// File: rtl/alu16_pkg.sv
// Package: shared operation codes and status-bit positions for the ALU.
// Assumes the status byte layout C=0, Z=1, N=2, V=7.
package alu16_pkg;
    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUBC = 4'd3,
        OP_SUB  = 4'd4,
        OP_CMP  = 4'd5,
        OP_DADD = 4'd6,
        OP_BIT  = 4'd7,
        OP_BIC  = 4'd8,
        OP_BIS  = 4'd9,
        OP_XOR  = 4'd10,
        OP_AND  = 4'd11
    } alu_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 7;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/alu_addsub.sv
// Binary adder with size select.
// Computes a+b+cin at word or byte width and reports the carry out and the
// signed overflow of that width. Assumes the caller has already inverted b
// for subtraction; in byte mode only bits 7:0 of a and b are used.
module alu_addsub #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          c_i,
    input  logic          byte_i,
    output logic [DW-1:0] sum_o,
    output logic          c_o,
    output logic          v_o
);
    localparam int BW = alu16_pkg::BYTE_W;

    logic [DW:0] full_w;
    logic [BW:0] full_b;
    logic        sa, sb, sr;

    // Form both width sums in parallel.
    always_comb begin
        full_w = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(c_i);
        full_b = {1'b0, a_i[BW-1:0]} + {1'b0, b_i[BW-1:0]} + (BW+1)'(c_i);
    end

    // Select the active width and derive carry and overflow.
    always_comb begin
        if (byte_i) begin
            sum_o = {{(DW-BW){1'b0}}, full_b[BW-1:0]};
            c_o   = full_b[BW];
            sa    = a_i[BW-1];
            sb    = b_i[BW-1];
            sr    = full_b[BW-1];
        end else begin
            sum_o = full_w[DW-1:0];
            c_o   = full_w[DW];
            sa    = a_i[DW-1];
            sb    = b_i[DW-1];
            sr    = full_w[DW-1];
        end
        v_o = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu_bcd.sv
// Packed-decimal adder.
// Adds ND nibble digits with a rippling decimal carry and no carry-in.
// A digit sum above 9 is corrected by +6. Byte mode reports the carry out of
// digit 1. Assumes ND >= 2.
module alu_bcd #(
    parameter int ND = 4
) (
    input  logic [4*ND-1:0] a_i,
    input  logic [4*ND-1:0] b_i,
    input  logic            byte_i,
    output logic [4*ND-1:0] sum_o,
    output logic            c_o
);
    logic [ND:0] cy;

    assign cy[0] = 1'b0;

    for (genvar g = 0; g < ND; g++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fix;
        logic       big;

        // One decimal digit with +6 correction.
        always_comb begin
            raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + 5'(cy[g]);
            big = (raw > 5'd9);
            fix = big ? raw + 5'd6 : raw;
        end

        assign sum_o[4*g +: 4] = fix[3:0];
        assign cy[g+1]         = big;

        // Valid input digits always give a valid output digit.
        always_comb begin
            // R5
            digit_valid_chk: assert (!((a_i[4*g +: 4] <= 4'd9) && (b_i[4*g +: 4] <= 4'd9))
                                     || (sum_o[4*g +: 4] <= 4'd9));
        end
    end

    // Carry out of the active size.
    assign c_o = byte_i ? cy[2] : cy[ND];
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: returns the bitwise result for and, bit test, bit clear,
// bit set and exclusive-or, and passes src through for move. Gives 0 for
// any other code. Size masking is left to the caller.
module alu_logic #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [3:0]    op_i,
    output logic [DW-1:0] res_o
);
    import alu16_pkg::*;

    // Pick the bitwise function.
    always_comb begin
        unique case (op_i)
            OP_MOV:         res_o = b_i;
            OP_AND, OP_BIT: res_o = a_i & b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_BIS:         res_o = a_i | b_i;
            OP_XOR:         res_o = a_i ^ b_i;
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
// Top of the two-operand ALU.
// Purely combinational. It routes the operands to the binary adder, the
// decimal adder or the bitwise unit, applies byte masking, and builds the
// status byte. Only C, Z, N and V are ever rewritten. Assumes DW is a
// multiple of 4 and at least 16.
module alu16_core #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    input  logic [3:0]    op_i,
    input  logic          byte_i,
    input  logic [7:0]    stat_i,
    output logic [DW-1:0] res_o,
    output logic          wr_o,
    output logic [7:0]    stat_o
);
    import alu16_pkg::*;

    localparam int BW = BYTE_W;
    localparam int ND = DW / 4;

    logic [DW-1:0] a, b, b_add;
    logic          cin;
    logic [DW-1:0] add_sum, bcd_sum, log_res, raw;
    logic          add_c, add_v, bcd_c;
    logic          is_sub;
    logic          z, n;

    // Mask the operands to the active size.
    always_comb begin
        a = byte_i ? {{(DW-BW){1'b0}}, dst_i[BW-1:0]} : dst_i;
        b = byte_i ? {{(DW-BW){1'b0}}, src_i[BW-1:0]} : src_i;
    end

    // Choose the adder's second operand and its carry-in.
    always_comb begin
        is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
        b_add  = is_sub ? ~b : b;
        unique case (op_i)
            OP_ADDC, OP_SUBC: cin = stat_i[FLG_C];
            OP_SUB, OP_CMP:   cin = 1'b1;
            default:          cin = 1'b0;
        endcase
    end

    alu_addsub #(.DW(DW)) u_add (
        .a_i(a), .b_i(b_add), .c_i(cin), .byte_i(byte_i),
        .sum_o(add_sum), .c_o(add_c), .v_o(add_v)
    );

    alu_bcd #(.ND(ND)) u_bcd (
        .a_i(a), .b_i(b), .byte_i(byte_i),
        .sum_o(bcd_sum), .c_o(bcd_c)
    );

    alu_logic #(.DW(DW)) u_log (
        .a_i(a), .b_i(b), .op_i(op_i), .res_o(log_res)
    );

    // Select the unit output and the write-back enable.
    always_comb begin
        unique case (op_i)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: raw = add_sum;
            OP_DADD:                                  raw = bcd_sum;
            default:                                  raw = log_res;
        endcase
        wr_o = (op_i <= OP_AND) && (op_i != OP_CMP) && (op_i != OP_BIT);
    end

    // Size masking and the size-dependent Z and N.
    always_comb begin
        res_o = byte_i ? {{(DW-BW){1'b0}}, raw[BW-1:0]} : raw;
        z     = (res_o == '0);
        n     = byte_i ? res_o[BW-1] : res_o[DW-1];
    end

    // Rewrite the flag bits the operation defines.
    always_comb begin
        stat_o = stat_i;
        unique case (op_i)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
                stat_o[FLG_C] = add_c;
                stat_o[FLG_Z] = z;
                stat_o[FLG_N] = n;
                stat_o[FLG_V] = add_v;
            end
            OP_DADD: begin
                stat_o[FLG_C] = bcd_c;
                stat_o[FLG_Z] = z;
                stat_o[FLG_N] = n;
            end
            OP_AND, OP_BIT: begin
                stat_o[FLG_C] = ~z;
                stat_o[FLG_Z] = z;
                stat_o[FLG_N] = n;
                stat_o[FLG_V] = 1'b0;
            end
            OP_XOR: begin
                stat_o[FLG_C] = ~z;
                stat_o[FLG_Z] = z;
                stat_o[FLG_N] = n;
                stat_o[FLG_V] = byte_i ? (a[BW-1] & b[BW-1]) : (a[DW-1] & b[DW-1]);
            end
            default: ;
        endcase
    end

    // Checks on the combined outputs.
    always_comb begin
        // R1
        flagonly_nowrite_chk: assert (!((op_i == OP_CMP) || (op_i == OP_BIT)) || !wr_o);
        // R9
        byte_upper_zero_chk: assert (!byte_i || (res_o[DW-1:BW] == '0));
        // R7
        reserved_bits_chk: assert (stat_o[6:3] == stat_i[6:3]);
        // R10
        move_keeps_flags_chk: assert ((op_i != OP_MOV) || ((stat_o == stat_i) && (res_o == b)));
        // R4
        no_overflow_chk: assert (!((op_i == OP_ADD) && !byte_i && (dst_i[DW-1] != src_i[DW-1]))
                                 || !stat_o[FLG_V]);
    end
endmodule

// File: tb/sim_alu16_core.sv
// Scoreboard bench for alu16_core. A driver task applies a vector and pushes
// the expected outputs into a queue. A monitor pops each item on the falling
// edge and compares it with the outputs.
module sim_alu16_core;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dst_i = '0, src_i = '0;
    logic [3:0]  op_i = '0;
    logic        byte_i = 1'b0;
    logic [7:0]  stat_i = '0;
    logic [15:0] res_o;
    logic        wr_o;
    logic [7:0]  stat_o;

    typedef struct {
        logic [24:0] exp;
        string       tag;
        logic [3:0]  op;
        logic        sz;
    } item_t;

    item_t queue_q[$];
    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    logic  done = 1'b0;

    alu16_core u0 (
        .dst_i(dst_i), .src_i(src_i), .op_i(op_i), .byte_i(byte_i),
        .stat_i(stat_i), .res_o(res_o), .wr_o(wr_o), .stat_o(stat_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, written from the requirements: returns {wr, stat, res}.
    function automatic logic [24:0] model(input logic [3:0] op, input logic sz,
                                          input logic [15:0] d, input logic [15:0] s,
                                          input logic [7:0] st);
        int unsigned msk, top, x, y, t, r, cy, dig;
        logic w;
        logic [7:0] f;
        msk = sz ? 32'hFF : 32'hFFFF;
        top = sz ? 32'h80 : 32'h8000;
        x = d & msk;
        y = s & msk;
        f = st;
        w = 1'b0;
        r = 0;
        case (op)
            4'd0: begin r = y; w = 1'b1; end
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
                if (op >= 4'd3) y = (~y) & msk;
                if (op == 4'd1) t = x + y;
                else if (op == 4'd4 || op == 4'd5) t = x + y + 1;
                else t = x + y + st[0];
                r = t & msk;
                w = (op != 4'd5);
                f[0] = (t > msk);
                f[1] = (r == 0);
                f[2] = ((r & top) != 0);
                f[7] = (((x & top) == (y & top)) && ((r & top) != (x & top)));
            end
            4'd6: begin
                cy = 0;
                for (int k = 0; k < (sz ? 2 : 4); k++) begin
                    dig = ((x >> (4*k)) & 15) + ((y >> (4*k)) & 15) + cy;
                    if (dig > 9) begin dig = dig + 6; cy = 1; end else cy = 0;
                    r = r | ((dig & 15) << (4*k));
                end
                w = 1'b1;
                f[0] = cy[0];
                f[1] = (r == 0);
                f[2] = ((r & top) != 0);
            end
            4'd7, 4'd11, 4'd10: begin
                r = (op == 4'd10) ? (x ^ y) : (x & y);
                w = (op != 4'd7);
                f[1] = (r == 0);
                f[0] = (r != 0);
                f[2] = ((r & top) != 0);
                f[7] = (op == 4'd10) ? (((x & top) != 0) && ((y & top) != 0)) : 1'b0;
            end
            4'd8: begin r = x & ~y & msk; w = 1'b1; end
            4'd9: begin r = x | y; w = 1'b1; end
            default: begin r = 0; w = 1'b0; end
        endcase
        return {w, f, r[15:0]};
    endfunction

    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'd0:             return "R10";
            4'd1, 4'd2:       return "R2";
            4'd3, 4'd4:       return "R3";
            4'd6:             return "R5";
            4'd7, 4'd10:      return "R11";
            4'd8, 4'd9, 4'd11: return "R6";
            default:          return "R1";
        endcase
    endfunction

    // Driver: apply one vector and record what must come out.
    task automatic drive(input logic [3:0] op, input logic sz, input logic [15:0] d,
                         input logic [15:0] s, input logic [7:0] st, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        op_i = op; byte_i = sz; dst_i = d; src_i = s; stat_i = st;
        it.exp = model(op, sz, d, s, st);
        it.tag = tag;
        it.op  = op;
        it.sz  = sz;
        queue_q.push_back(it);
    endtask

    // Monitor: compare the settled outputs with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && queue_q.size() > 0) begin
            item_t it;
            it = queue_q.pop_front();
            checks++;
            if ({wr_o, stat_o, res_o} !== it.exp) begin
                failures++;
                $display("FAIL %s op=%0d byte=%0d actual wr=%0b stat=%h res=%h expected wr=%0b stat=%h res=%h",
                         it.tag, it.op, it.sz, wr_o, stat_o, res_o,
                         it.exp[24], it.exp[23:16], it.exp[15:0]);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R2 carry out of word and byte; R4 byte overflow on 0x80+0x80
        drive(4'd1, 1'b0, 16'hFFFF, 16'h0001, 8'h00, "R2");
        drive(4'd1, 1'b1, 16'h3480, 16'h5680, 8'h00, "R4");
        drive(4'd2, 1'b0, 16'h1234, 16'h0001, 8'h01, "R2");
        // R3 borrow gives C=0, no borrow gives C=1; subtract-with-carry with C=0
        drive(4'd4, 1'b0, 16'h0005, 16'h0007, 8'h00, "R3");
        drive(4'd4, 1'b0, 16'h0007, 16'h0007, 8'h00, "R3");
        drive(4'd3, 1'b0, 16'h0010, 16'h0001, 8'h00, "R3");
        // R4 word overflow at both signed boundaries
        drive(4'd1, 1'b0, 16'h7FFF, 16'h0001, 8'h00, "R4");
        drive(4'd4, 1'b0, 16'h8000, 16'h0001, 8'h00, "R4");
        // R5 decimal ripple across digits, full carry out, byte-mode carry
        drive(4'd6, 1'b0, 16'h0999, 16'h0001, 8'h00, "R5");
        drive(4'd6, 1'b0, 16'h9999, 16'h0001, 8'h80, "R5");
        drive(4'd6, 1'b1, 16'h1299, 16'h3401, 8'h00, "R5");
        // R1 flag-only and unused codes
        drive(4'd5, 1'b0, 16'h0003, 16'h0003, 8'h00, "R1");
        drive(4'd7, 1'b0, 16'hF0F0, 16'h0F0F, 8'h00, "R1");
        drive(4'd13, 1'b0, 16'hAAAA, 16'h5555, 8'h85, "R1");
        // R7 reserved status bits pass through
        drive(4'd1, 1'b0, 16'h0001, 16'h0001, 8'h78, "R7");
        // R8 byte-mode N from bit 7
        drive(4'd1, 1'b1, 16'hFF7F, 16'h0001, 8'h00, "R8");
        // R9 upper bits ignored and cleared in byte mode
        drive(4'd9, 1'b1, 16'hAB00, 16'hCD00, 8'h00, "R9");
        // R10 move keeps flags
        drive(4'd0, 1'b0, 16'h1111, 16'hBEEF, 8'hFF, "R10");
        drive(4'd8, 1'b0, 16'hFFFF, 16'h00FF, 8'h87, "R10");
        // R11 xor overflow with both operands negative
        drive(4'd10, 1'b0, 16'h8001, 16'h8001, 8'h00, "R11");
        drive(4'd11, 1'b1, 16'h0080, 16'h0080, 8'h81, "R11");
        // R6 bitwise results
        drive(4'd8, 1'b0, 16'hF0F0, 16'h3030, 8'h00, "R6");
        drive(4'd11, 1'b0, 16'hF0F0, 16'h3C3C, 8'h00, "R6");

        // Pseudo-random sweep over every code and both sizes.
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] dv, sv;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            dv = lfsr[15:0] ^ lfsr[31:16];
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            sv = lfsr[31:16];
            drive(4'(i % 16), lfsr[3], dv, sv, lfsr[11:4], op_tag(4'(i % 16)));
        end

        while (queue_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule